// File: doc/BRIEF.md
# IDE Channel Register Window Decoder

This block sits between a system bus and one IDE channel. It decodes a 4 KB memory-mapped window in which each register takes a 16-byte slot, and it turns every legal access into a one-cycle strobe toward the data port, the taskfile, the status path or the command path. The device side is reduced to strobes, a shared write-data bus and read-data inputs. Register data is little-endian: byte and halfword values sit in the low bits of the 32-bit data bus.

Two registers live inside the block. The first is a 32-bit timing register that software can read and write. The second is an interrupt state word with two bits in it. Bit 31 latches the DMA interrupt and is cleared by writing a one to it. Bit 30 follows the live drive interrupt. Each interrupt input is also passed straight through to its own output line.

Every register accepts only certain access sizes. A read that hits no register, or that uses a size the register does not allow, returns all ones. A write of that kind changes nothing and raises no strobe.

Top module: `ide_mmio_frontend`

## Requirements
- R1: The register slot is the byte address shifted right by 4. Address bits 3:0 do not affect decoding.
- R2: Slot 0 is the data port. It accepts only 2-byte and 4-byte accesses, which raise dp_rd or dp_wr. dp_wide is 1 for a 4-byte access. A 2-byte read returns the low 16 bits of dp_rdata, zero-extended.
- R3: Slots 1 to 7 are taskfile registers. They accept only 1-byte accesses, which raise tf_rd or tf_wr with tf_sel equal to the slot number. A read returns tf_rdata zero-extended.
- R4: Slots 8 and 0x16 (byte addresses 0x080 and 0x160) both give the status byte on a 1-byte read (st_rd) and take the command byte on a 1-byte write (cmd_wr).
- R5: Slot 0x20 (byte address 0x200) is a 32-bit timing register. A 4-byte write stores req_wdata, and a 4-byte read returns the stored value.
- R6: Slot 0x30 (byte address 0x300) is the interrupt state word, read with a 4-byte access. Bit 31 is the DMA bit and bit 30 is the drive bit; all other bits read as 0. When an interrupt input changes level, its bit takes the new level at the next clock edge.
- R7: A 4-byte write to slot 0x30 with bit 31 of the data set clears bit 31. No write changes bit 30 or any other bit.
- R8: dma_irq_out equals dma_irq_in, and drv_irq_out equals drv_irq_in, with no clock delay.
- R9: A read from an unmapped slot, or with a size the slot does not allow, returns 0xFFFFFFFF. A write of that kind raises no strobe and changes no register.
- R10: Reset clears the timing register and the interrupt state word to zero.
- R11: If the DMA input changes level in the same cycle as a clearing write, the level change wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 12 | Byte address inside the window |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, little-endian |
| rd_data | output | 32 | Read data for the current access |
| dev_wdata | output | 32 | Write data forwarded to the device side |
| dp_rd | output | 1 | Data port read strobe |
| dp_wr | output | 1 | Data port write strobe |
| dp_wide | output | 1 | Data port access is 4 bytes |
| dp_rdata | input | 32 | Data port read value |
| tf_rd | output | 1 | Taskfile read strobe |
| tf_wr | output | 1 | Taskfile write strobe |
| tf_sel | output | 3 | Taskfile register number |
| tf_rdata | input | 8 | Taskfile read value |
| st_rd | output | 1 | Status read strobe |
| st_rdata | input | 8 | Status byte |
| cmd_wr | output | 1 | Command write strobe |
| dma_irq_in | input | 1 | DMA interrupt level |
| drv_irq_in | input | 1 | Drive interrupt level |
| dma_irq_out | output | 1 | DMA interrupt forwarded |
| drv_irq_out | output | 1 | Drive interrupt forwarded |

## Verification
The bench goes after the size gates on each slot: a 1-byte data-port read, a 2-byte taskfile read, and byte or halfword accesses to the timing and interrupt slots. A decoder that gates too loosely would raise device strobes or return register values where all ones are due. It also tests the two status aliases and addresses with nonzero low bits, which a decoder using the wrong address bits would miss or misroute. For the interrupt word, the bench checks that clearing the DMA bit works while the input is still high, that writes cannot touch the drive bit, and that a level change in the same cycle as a clear wins. A design that got this priority wrong would lose an interrupt that arrives just as software clears the previous one.

// File: rtl/ide_mmio_frontend.sv
module ide_mmio_frontend #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] MISS_VAL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              dp_rd,
  output logic              dp_wr,
  output logic              dp_wide,
  input  logic [DATA_W-1:0] dp_rdata,
  output logic              tf_rd,
  output logic              tf_wr,
  output logic [2:0]        tf_sel,
  input  logic [7:0]        tf_rdata,
  output logic              st_rd,
  input  logic [7:0]        st_rdata,
  output logic              cmd_wr,
  input  logic              dma_irq_in,
  input  logic              drv_irq_in,
  output logic              dma_irq_out,
  output logic              drv_irq_out
);
  localparam int SLOT_W = ADDR_W - 4;
  localparam logic [SLOT_W-1:0] S_DATA  = SLOT_W'(0);
  localparam logic [SLOT_W-1:0] S_STAT0 = SLOT_W'(8);
  localparam logic [SLOT_W-1:0] S_STAT1 = SLOT_W'(22);
  localparam logic [SLOT_W-1:0] S_TIME  = SLOT_W'(32);
  localparam logic [SLOT_W-1:0] S_IRQ   = SLOT_W'(48);

  logic [SLOT_W-1:0] slot;
  logic sz1, sz2, sz4;
  logic hit_dp, hit_tf, hit_sc, hit_tm, hit_iq;
  logic rd_go, wr_go;

  logic [DATA_W-1:0] timing_q;
  logic              irq_dma_q, irq_drv_q;
  logic              dma_prev_q, drv_prev_q;

  assign slot = req_addr[ADDR_W-1:4];
  assign sz1  = (req_size == 3'd1);
  assign sz2  = (req_size == 3'd2);
  assign sz4  = (req_size == 3'd4);

  assign hit_dp = (slot == S_DATA) && (sz2 || sz4);
  assign hit_tf = (slot >= SLOT_W'(1)) && (slot <= SLOT_W'(7)) && sz1;
  assign hit_sc = ((slot == S_STAT0) || (slot == S_STAT1)) && sz1;
  assign hit_tm = (slot == S_TIME) && sz4;
  assign hit_iq = (slot == S_IRQ) && sz4;

  assign rd_go = req_valid && !req_write;
  assign wr_go = req_valid &&  req_write;

  assign dp_rd   = rd_go && hit_dp;
  assign dp_wr   = wr_go && hit_dp;
  assign dp_wide = sz4;
  assign tf_rd   = rd_go && hit_tf;
  assign tf_wr   = wr_go && hit_tf;
  assign tf_sel  = slot[2:0];
  assign st_rd   = rd_go && hit_sc;
  assign cmd_wr  = wr_go && hit_sc;
  assign dev_wdata = req_wdata;

  assign dma_irq_out = dma_irq_in;
  assign drv_irq_out = drv_irq_in;

  always_comb begin
    rd_data = MISS_VAL;
    if (hit_dp)      rd_data = sz4 ? dp_rdata : {{(DATA_W-16){1'b0}}, dp_rdata[15:0]};
    else if (hit_tf) rd_data = {{(DATA_W-8){1'b0}}, tf_rdata};
    else if (hit_sc) rd_data = {{(DATA_W-8){1'b0}}, st_rdata};
    else if (hit_tm) rd_data = timing_q;
    else if (hit_iq) rd_data = {irq_dma_q, irq_drv_q, {(DATA_W-2){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timing_q   <= '0;
      irq_dma_q  <= 1'b0;
      irq_drv_q  <= 1'b0;
      dma_prev_q <= 1'b0;
      drv_prev_q <= 1'b0;
    end else begin
      dma_prev_q <= dma_irq_in;
      drv_prev_q <= drv_irq_in;
      if (wr_go && hit_tm) timing_q <= req_wdata;
      if (dma_irq_in != dma_prev_q)
        irq_dma_q <= dma_irq_in;
      else if (wr_go && hit_iq && req_wdata[DATA_W-1])
        irq_dma_q <= 1'b0;
      if (drv_irq_in != drv_prev_q)
        irq_drv_q <= drv_irq_in;
    end
  end
endmodule

// File: rtl/ide_mmio_frontend_chk.sv
module ide_mmio_frontend_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [2:0]        req_size,
  input logic [DATA_W-1:0] req_wdata,
  input logic              dp_rd,
  input logic              dp_wr,
  input logic              tf_rd,
  input logic              tf_wr,
  input logic              st_rd,
  input logic              cmd_wr,
  input logic              dma_irq_in,
  input logic              drv_irq_in,
  input logic              irq_dma_q,
  input logic              irq_drv_q,
  input logic [DATA_W-1:0] timing_q
);
  logic tm_wr, iq_clr;
  assign tm_wr  = req_valid && req_write && (req_addr[ADDR_W-1:4] == (ADDR_W-4)'(32)) && (req_size == 3'd4);
  assign iq_clr = req_valid && req_write && (req_addr[ADDR_W-1:4] == (ADDR_W-4)'(48)) && (req_size == 3'd4)
                  && req_wdata[DATA_W-1];

  a_r2_dp_size: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rd || dp_wr) |-> (req_size == 3'd2 || req_size == 3'd4));
  a_r3_tf_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_rd || tf_wr || st_rd || cmd_wr) |-> (req_size == 3'd1));
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dp_rd, dp_wr, tf_rd, tf_wr, st_rd, cmd_wr}));
  a_r9_timing_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tm_wr |=> $stable(timing_q));
  a_r6_drv_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_irq_in) |=> irq_drv_q);
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_clr && $stable(dma_irq_in)) |=> !irq_dma_q);
  a_r10_reset: assert property (@(posedge clk)
    !rst_n |=> (timing_q == '0 && !irq_dma_q && !irq_drv_q));
endmodule

bind ide_mmio_frontend ide_mmio_frontend_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
  .dp_rd(dp_rd), .dp_wr(dp_wr), .tf_rd(tf_rd), .tf_wr(tf_wr),
  .st_rd(st_rd), .cmd_wr(cmd_wr), .dma_irq_in(dma_irq_in), .drv_irq_in(drv_irq_in),
  .irq_dma_q(irq_dma_q), .irq_drv_q(irq_drv_q), .timing_q(timing_q)
);

// File: tb/ide_mmio_frontend_bench.sv
module ide_mmio_frontend_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data, dev_wdata;
  logic dp_rd, dp_wr, dp_wide, tf_rd, tf_wr, st_rd, cmd_wr;
  logic [2:0] tf_sel;
  logic [31:0] dp_rdata = 32'h1234_5678;
  logic [7:0]  tf_rdata = 8'hA5;
  logic [7:0]  st_rdata = 8'h5C;
  logic dma_irq_in = 1'b0, drv_irq_in = 1'b0;
  logic dma_irq_out, drv_irq_out;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ide_mmio_frontend u_ide_mmio_frontend (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rd_data(rd_data), .dev_wdata(dev_wdata), .dp_rd(dp_rd), .dp_wr(dp_wr),
    .dp_wide(dp_wide), .dp_rdata(dp_rdata), .tf_rd(tf_rd), .tf_wr(tf_wr),
    .tf_sel(tf_sel), .tf_rdata(tf_rdata), .st_rd(st_rd), .st_rdata(st_rdata),
    .cmd_wr(cmd_wr), .dma_irq_in(dma_irq_in), .drv_irq_in(drv_irq_in),
    .dma_irq_out(dma_irq_out), .drv_irq_out(drv_irq_out)
  );

  // {write, addr, size, wdata, expected rdata (reads only), strobes dp_rd,dp_wr,tf_rd,tf_wr,st_rd,cmd_wr}
  localparam int NV = 16;
  localparam logic [85:0] VEC [NV] = '{
    {1'b0, 12'h000, 3'd4, 32'h0, 32'h1234_5678, 6'b100000},
    {1'b0, 12'h004, 3'd2, 32'h0, 32'h0000_5678, 6'b100000},
    {1'b0, 12'h000, 3'd1, 32'h0, 32'hFFFF_FFFF, 6'b000000},
    {1'b1, 12'h00C, 3'd2, 32'h0, 32'h0,         6'b010000},
    {1'b0, 12'h030, 3'd1, 32'h0, 32'h0000_00A5, 6'b001000},
    {1'b0, 12'h07F, 3'd1, 32'h0, 32'h0000_00A5, 6'b001000},
    {1'b0, 12'h010, 3'd2, 32'h0, 32'hFFFF_FFFF, 6'b000000},
    {1'b1, 12'h050, 3'd1, 32'h0, 32'h0,         6'b000100},
    {1'b0, 12'h080, 3'd1, 32'h0, 32'h0000_005C, 6'b000010},
    {1'b0, 12'h163, 3'd1, 32'h0, 32'h0000_005C, 6'b000010},
    {1'b1, 12'h160, 3'd1, 32'h0, 32'h0,         6'b000001},
    {1'b1, 12'h080, 3'd4, 32'h0, 32'h0,         6'b000000},
    {1'b0, 12'h090, 3'd1, 32'h0, 32'hFFFF_FFFF, 6'b000000},
    {1'b0, 12'h200, 3'd2, 32'h0, 32'hFFFF_FFFF, 6'b000000},
    {1'b0, 12'h300, 3'd1, 32'h0, 32'hFFFF_FFFF, 6'b000000},
    {1'b0, 12'hFF0, 3'd4, 32'h0, 32'hFFFF_FFFF, 6'b000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [11:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    #1;
  endtask

  task automatic read_chk(input string req, input logic [11:0] a, input logic [2:0] s, input logic [31:0] exp);
    access(1'b0, a, s, 32'h0);
    check(req, rd_data, exp);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    read_chk("R10 timing reset", 12'h200, 3'd4, 32'h0);
    read_chk("R10 irq reset", 12'h300, 3'd4, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][85], VEC[i][84:73], VEC[i][72:70], VEC[i][69:38]);
      check($sformatf("R1/R2/R3/R4/R9 vec%0d strobes", i),
            {26'h0, dp_rd, dp_wr, tf_rd, tf_wr, st_rd, cmd_wr}, {26'h0, VEC[i][5:0]});
      if (!VEC[i][85])
        check($sformatf("R1/R2/R3/R4/R9 vec%0d rdata", i), rd_data, VEC[i][37:6]);
    end

    access(1'b1, 12'h058, 3'd1, 32'h0000_0077);
    check("R3 tf_sel", {29'h0, tf_sel}, 32'd5);
    check("R3 dev_wdata", dev_wdata, 32'h77);
    access(1'b1, 12'h000, 3'd4, 32'h0);
    check("R2 dp_wide", {31'h0, dp_wide}, 32'd1);

    access(1'b1, 12'h200, 3'd4, 32'hDEAD_BEEF);
    idle();
    read_chk("R5 timing readback", 12'h204, 3'd4, 32'hDEAD_BEEF);
    access(1'b1, 12'h200, 3'd2, 32'h0000_1111);
    idle();
    read_chk("R9 timing bad size write", 12'h200, 3'd4, 32'hDEAD_BEEF);

    @(negedge clk); dma_irq_in = 1'b1; #1;
    check("R8 dma out", {31'h0, dma_irq_out}, 32'd1);
    idle();
    read_chk("R6 dma bit set", 12'h300, 3'd4, 32'h8000_0000);
    access(1'b1, 12'h300, 3'd4, 32'h4000_0000);
    idle();
    read_chk("R7 no clear without bit31", 12'h300, 3'd4, 32'h8000_0000);
    access(1'b1, 12'h300, 3'd2, 32'h8000_0000);
    idle();
    read_chk("R9 irq bad size write", 12'h300, 3'd4, 32'h8000_0000);
    access(1'b1, 12'h300, 3'd4, 32'h8000_0000);
    idle();
    read_chk("R7 dma clear while high", 12'h300, 3'd4, 32'h0);

    @(negedge clk); drv_irq_in = 1'b1; #1;
    check("R8 drv out", {31'h0, drv_irq_out}, 32'd1);
    idle();
    read_chk("R6 drv bit set", 12'h300, 3'd4, 32'h4000_0000);
    access(1'b1, 12'h300, 3'd4, 32'hC000_0000);
    idle();
    read_chk("R7 drv bit not writable", 12'h300, 3'd4, 32'h4000_0000);
    @(negedge clk); drv_irq_in = 1'b0; #1;
    idle();
    read_chk("R6 drv bit follows low", 12'h300, 3'd4, 32'h0);

    @(negedge clk); dma_irq_in = 1'b0; #1;
    idle();
    @(negedge clk);
    dma_irq_in = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h300; req_size = 3'd4; req_wdata = 32'h8000_0000;
    #1;
    idle();
    read_chk("R11 change beats clear", 12'h300, 3'd4, 32'h8000_0000);

    idle();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    read_chk("R10 reset after activity", 12'h200, 3'd4, 32'h0);

    idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule